// File: doc/BRIEF.md
# Adaptive Dead-Time Gate-Drive Controller

This block is the clocked control core of a synchronous-buck half-bridge driver. Comparator outputs feed it: a three-level PWM command (as two bits), an active-low skip-mode pin, an active-low output disable, an undervoltage-lockout flag and a bit that reports the switch node as low. It drives two gate enables, one for the high-side switch and one for the low-side switch. It never turns one on while the other is on, and it keeps a gap between them.

The high-side switch turns on a fixed number of ticks after the low side has gone off. The low-side switch turns on a set number of ticks after the sensed switch node has collapsed. If the node never falls, a timeout turns the low side on anyway. A PWM input held at the middle level long enough shuts off both gates. The skip-mode pin can keep the low side off altogether. Disable and lockout force both gates off. All asynchronous inputs pass through synchronizer stages first, so every command reaches the gates three clock edges after it changes.

Top module: `gdt_ctrl`

## Requirements
- R1: While reset is asserted, both gate enables are low.
- R2: A low on `dis_n_i` drives both gate enables low on the third clock edge after the change. They stay low whatever PWM does for as long as the disable is held.
- R3: A high on `uvlo_i` drives both gate enables low on the third edge after the change. They stay low, whatever PWM does, until the flag clears.
- R4: PWM code {above,below} = 2'b10 is the high command and 2'b01 is the low command. With `skip_n_i` low, the low-side enable is off (dropped on the third edge if it was on) and the high side still works. With `skip_n_i` high, the low side follows the inverse of PWM.
- R5: On a change to the high command, the low-side enable drops on the third edge. The high-side enable rises HS_DEAD (5) edges after that.
- R6: On a change to the low command, the high-side enable drops on the third edge. The low-side enable rises LS_DEAD (4) edges after the synchronized switch-node-low bit has first been seen high in that wait, continuously.
- R7: If the switch node never reads low, the low-side enable rises SW_TIMEOUT (50) edges after the high side dropped.
- R8: PWM code 2'b00 held for TRI_HOLD (20) synchronized cycles turns both enables off on the 23rd edge after the change. A shorter middle level leaves the outputs unchanged.
- R9: The illegal code 2'b11 is handled exactly like 2'b00.
- R10: On leaving disable, lockout or the middle level, the block starts with both gates off and applies the normal dead time before turning on either gate.
- R11: The two gate enables are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_above_i | input | 1 | PWM above upper threshold |
| pwm_below_i | input | 1 | PWM below lower threshold |
| skip_n_i | input | 1 | Low keeps low-side gate off |
| dis_n_i | input | 1 | Low forces both gates off |
| uvlo_i | input | 1 | High: supply under lockout |
| sw_low_i | input | 1 | High: switch node sensed low |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |

## Verification
The assertions assume that every input reaches the controller only through the synchronizers, so a change is seen as one clean step. They also assume the switch-node sense bit tells the truth when it reads low. The bench holds each input steady for many cycles around every change. It changes inputs only on the falling clock edge. It drops the switch-node bit only while the controller is waiting to turn the low side on. That keeps every step inside those assumptions.

// File: rtl/gdt_pkg.sv
package gdt_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_HS_ON,
    ST_HS_LS_WAIT,
    ST_LS_ON,
    ST_LS_HS_WAIT
  } gdt_state_e;

  typedef enum logic [1:0] {
    CMD_LOW,
    CMD_HIGH,
    CMD_MID
  } pwm_cmd_e;

  function automatic pwm_cmd_e decode_pwm(input logic above, input logic below);
    if (above && !below)      return CMD_HIGH;
    else if (below && !above) return CMD_LOW;
    else                      return CMD_MID;
  endfunction
endpackage

// File: rtl/gdt_sync.sv
module gdt_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/gdt_tri_qual.sv
module gdt_tri_qual #(
  parameter int TRI_HOLD = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mid_i,
  output logic tri_o
);
  localparam int CW = $clog2(TRI_HOLD + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_full;

  assign cnt_full = (cnt_q == CW'(TRI_HOLD));

  always_comb begin
    if (!mid_i)        cnt_d = '0;
    else if (cnt_full) cnt_d = cnt_q;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tri_o = mid_i && cnt_full;

  // R8
  tri_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(TRI_HOLD));

  // R8
  tri_needs_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tri_o |-> $past(mid_i));
endmodule

// File: rtl/gdt_fsm.sv
module gdt_fsm
  import gdt_pkg::*;
#(
  parameter int HS_DEAD    = 5,
  parameter int LS_DEAD    = 4,
  parameter int SW_TIMEOUT = 50
) (
  input  logic     clk,
  input  logic     rst_n,
  input  pwm_cmd_e cmd_i,
  input  logic     force_off_i,
  input  logic     ls_allow_i,
  input  logic     sw_low_i,
  output logic     hs_en_o,
  output logic     ls_en_o
);
  localparam int TMAX = (SW_TIMEOUT > HS_DEAD) ? SW_TIMEOUT : HS_DEAD;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int SW   = $clog2(LS_DEAD + 1);

  gdt_state_e    st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [SW-1:0] sns_q, sns_d;
  logic          hs_gap_done, ls_sense_done, ls_timeout;

  assign hs_gap_done   = (tmr_q == TW'(HS_DEAD - 1));
  assign ls_sense_done = sw_low_i && (sns_q == SW'(LS_DEAD - 1));
  assign ls_timeout    = (tmr_q == TW'(SW_TIMEOUT - 1));

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q;
    sns_d = sns_q;
    if (force_off_i) begin
      st_d = ST_OFF;
    end else if (cmd_i != CMD_MID) begin
      case (st_q)
        ST_OFF: begin
          if (cmd_i == CMD_HIGH) st_d = ST_LS_HS_WAIT;
          else if (ls_allow_i)   st_d = ST_HS_LS_WAIT;
        end
        ST_HS_ON: begin
          if (cmd_i == CMD_LOW) st_d = ST_HS_LS_WAIT;
        end
        ST_LS_ON: begin
          if (cmd_i == CMD_HIGH) st_d = ST_LS_HS_WAIT;
          else if (!ls_allow_i)  st_d = ST_OFF;
        end
        ST_LS_HS_WAIT: begin
          if (cmd_i == CMD_LOW) st_d = ST_HS_LS_WAIT;
          else if (hs_gap_done) st_d = ST_HS_ON;
          else                  tmr_d = tmr_q + 1'b1;
        end
        ST_HS_LS_WAIT: begin
          if (cmd_i == CMD_HIGH)                 st_d = ST_LS_HS_WAIT;
          else if (!ls_allow_i)                  st_d = ST_OFF;
          else if (ls_sense_done || ls_timeout)  st_d = ST_LS_ON;
          else begin
            tmr_d = tmr_q + 1'b1;
            sns_d = sw_low_i ? sns_q + 1'b1 : '0;
          end
        end
        default: st_d = ST_OFF;
      endcase
    end
    if (st_d != st_q) begin
      tmr_d = '0;
      sns_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_OFF;
      tmr_q <= '0;
      sns_q <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
      sns_q <= sns_d;
    end
  end

  assign hs_en_o = (st_q == ST_HS_ON);
  assign ls_en_o = (st_q == ST_LS_ON);

  // R5
  hs_rise_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en_o) |-> !$past(ls_en_o));

  // R6
  ls_rise_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_en_o) |-> !$past(hs_en_o));

  // R2
  force_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_off_i |=> (!hs_en_o && !ls_en_o));

  // R4
  skip_blocks_ls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ls_allow_i |=> !ls_en_o);

  // R8
  mid_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_MID && !force_off_i) |=> $stable(hs_en_o) && $stable(ls_en_o));
endmodule

// File: rtl/gdt_ctrl.sv
module gdt_ctrl
  import gdt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HS_DEAD     = 5,
  parameter int LS_DEAD     = 4,
  parameter int TRI_HOLD    = 20,
  parameter int SW_TIMEOUT  = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_above_i,
  input  logic pwm_below_i,
  input  logic skip_n_i,
  input  logic dis_n_i,
  input  logic uvlo_i,
  input  logic sw_low_i,
  output logic hs_en_o,
  output logic ls_en_o
);
  localparam int NIN = 6;

  logic [1:0]     rst_sync_q;
  logic           rst_int_n;
  logic [NIN-1:0] raw_in, syn_in;
  logic           above_s, below_s, skip_n_s, dis_n_s, uvlo_s, sw_low_s;
  pwm_cmd_e       cmd;
  logic           mid_level, tri_hit, force_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign raw_in = {sw_low_i, uvlo_i, dis_n_i, skip_n_i, pwm_below_i, pwm_above_i};

  gdt_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (raw_in),
    .q_o   (syn_in)
  );

  assign {sw_low_s, uvlo_s, dis_n_s, skip_n_s, below_s, above_s} = syn_in;

  assign cmd       = decode_pwm(above_s, below_s);
  assign mid_level = (cmd == CMD_MID);

  gdt_tri_qual #(.TRI_HOLD(TRI_HOLD)) u_tri (
    .clk   (clk),
    .rst_n (rst_int_n),
    .mid_i (mid_level),
    .tri_o (tri_hit)
  );

  assign force_off = !dis_n_s || uvlo_s || tri_hit;

  gdt_fsm #(.HS_DEAD(HS_DEAD), .LS_DEAD(LS_DEAD), .SW_TIMEOUT(SW_TIMEOUT)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cmd_i       (cmd),
    .force_off_i (force_off),
    .ls_allow_i  (skip_n_s),
    .sw_low_i    (sw_low_s),
    .hs_en_o     (hs_en_o),
    .ls_en_o     (ls_en_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!hs_en_o && !ls_en_o));
endmodule

// File: tb/gdt_ctrl_bench.sv
module gdt_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic above, below, skip_n, dis_n, uvlo, sw_low;
  logic hs, ls;
  int   cyc = 0;
  int   total = 0;
  int   bad = 0;
  int   overlap = 0;
  int   c, d;

  typedef struct {
    int    when;
    logic  hs;
    logic  ls;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gdt_ctrl u_gdt_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwm_above_i (above),
    .pwm_below_i (below),
    .skip_n_i    (skip_n),
    .dis_n_i     (dis_n),
    .uvlo_i      (uvlo),
    .sw_low_i    (sw_low),
    .hs_en_o     (hs),
    .ls_en_o     (ls)
  );

  task automatic expect_at(input int when, input logic eh, input logic el, input string tag);
    exp_t e;
    e.when = when; e.hs = eh; e.ls = el; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic wait_to(input int when);
    while (cyc < when) @(negedge clk);
  endtask

  task automatic set_pwm(input logic a, input logic b);
    above = a; below = b;
  endtask

  task automatic finish_run();
    total++;
    if (overlap != 0) begin
      bad++;
      $display("FAIL R11 overlap cycles actual=%0d expected=0", overlap);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].when <= cyc) begin
      total++;
      if (hs !== sb[0].hs || ls !== sb[0].ls) begin
        bad++;
        $display("FAIL %s at cycle %0d actual hs=%b ls=%b expected hs=%b ls=%b",
                 sb[0].tag, cyc, hs, ls, sb[0].hs, sb[0].ls);
      end
      void'(sb.pop_front());
    end
    if (hs === 1'b1 && ls === 1'b1) overlap++;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    set_pwm(1'b0, 1'b1);
    skip_n = 1'b1; dis_n = 1'b0; uvlo = 1'b0; sw_low = 1'b1;
    repeat (4) @(negedge clk);
    total++;
    if (hs !== 1'b0 || ls !== 1'b0) begin
      bad++;
      $display("FAIL R1 in reset actual hs=%b ls=%b expected hs=0 ls=0", hs, ls);
    end
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R6 / R10: leave disable with low command, node already low
    c = cyc; dis_n = 1'b1;
    expect_at(c + 6, 1'b0, 1'b0, "R10 gap before ls");
    expect_at(c + 7, 1'b0, 1'b1, "R6 ls on after sense");
    wait_to(c + 15);

    // R5: rising command
    c = cyc; set_pwm(1'b1, 1'b0);
    expect_at(c + 2, 1'b0, 1'b1, "R5 ls still on");
    expect_at(c + 3, 1'b0, 1'b0, "R5 ls off");
    expect_at(c + 7, 1'b0, 1'b0, "R5 dead time");
    expect_at(c + 8, 1'b1, 1'b0, "R5 hs on");
    wait_to(c + 15);

    // R7: falling command, node stays high -> timeout
    c = cyc; sw_low = 1'b0; set_pwm(1'b0, 1'b1);
    expect_at(c + 2, 1'b1, 1'b0, "R6 hs still on");
    expect_at(c + 3, 1'b0, 1'b0, "R6 hs off");
    expect_at(c + 52, 1'b0, 1'b0, "R7 before timeout");
    expect_at(c + 53, 1'b0, 1'b1, "R7 timeout ls on");
    wait_to(c + 60);

    // R6: node falls in the middle of the wait
    c = cyc; set_pwm(1'b1, 1'b0);
    expect_at(c + 8, 1'b1, 1'b0, "R5 hs on again");
    wait_to(c + 12);
    c = cyc; set_pwm(1'b0, 1'b1);
    wait_to(c + 13);
    d = cyc; sw_low = 1'b1;
    expect_at(d + 5, 1'b0, 1'b0, "R6 sense settling");
    expect_at(d + 6, 1'b0, 1'b1, "R6 ls on after late sense");
    wait_to(d + 10);

    // R4: skip mode
    c = cyc; skip_n = 1'b0;
    expect_at(c + 2, 1'b0, 1'b1, "R4 ls before skip");
    expect_at(c + 3, 1'b0, 1'b0, "R4 skip drops ls");
    expect_at(c + 20, 1'b0, 1'b0, "R4 ls held off");
    wait_to(c + 21);
    c = cyc; set_pwm(1'b1, 1'b0);
    expect_at(c + 8, 1'b1, 1'b0, "R4 hs works in skip");
    wait_to(c + 12);
    c = cyc; set_pwm(1'b0, 1'b1);
    expect_at(c + 30, 1'b0, 1'b0, "R4 ls stays off in skip");
    wait_to(c + 31);
    c = cyc; skip_n = 1'b1;
    expect_at(c + 6, 1'b0, 1'b0, "R4 resume gap");
    expect_at(c + 7, 1'b0, 1'b1, "R4 ls follows inverse pwm");
    wait_to(c + 10);

    // R2: disable
    c = cyc; set_pwm(1'b1, 1'b0);
    wait_to(c + 12);
    c = cyc; dis_n = 1'b0;
    expect_at(c + 2, 1'b1, 1'b0, "R2 before disable");
    expect_at(c + 3, 1'b0, 1'b0, "R2 disable clears");
    wait_to(c + 5);
    c = cyc; set_pwm(1'b0, 1'b1);
    expect_at(c + 10, 1'b0, 1'b0, "R2 held off");
    wait_to(c + 12);
    c = cyc; dis_n = 1'b1;
    expect_at(c + 6, 1'b0, 1'b0, "R10 gap after disable");
    expect_at(c + 7, 1'b0, 1'b1, "R10 ls after disable");
    wait_to(c + 10);

    // R3: undervoltage lockout
    c = cyc; uvlo = 1'b1;
    expect_at(c + 2, 1'b0, 1'b1, "R3 before lockout");
    expect_at(c + 3, 1'b0, 1'b0, "R3 lockout clears");
    wait_to(c + 5);
    c = cyc; set_pwm(1'b1, 1'b0);
    expect_at(c + 15, 1'b0, 1'b0, "R3 held off");
    wait_to(c + 20);
    c = cyc; uvlo = 1'b0;
    expect_at(c + 7, 1'b0, 1'b0, "R10 gap after lockout");
    expect_at(c + 8, 1'b1, 1'b0, "R10 hs after lockout");
    wait_to(c + 10);

    // R8: short middle level has no effect
    c = cyc; set_pwm(1'b0, 1'b0);
    expect_at(c + 5, 1'b1, 1'b0, "R8 short mid hold");
    wait_to(c + 10);
    set_pwm(1'b1, 1'b0);
    expect_at(c + 12, 1'b1, 1'b0, "R8 short mid hold");
    expect_at(c + 30, 1'b1, 1'b0, "R8 short mid no effect");
    wait_to(c + 31);

    // R8: long middle level shuts off
    c = cyc; set_pwm(1'b0, 1'b0);
    expect_at(c + 22, 1'b1, 1'b0, "R8 before qualify");
    expect_at(c + 23, 1'b0, 1'b0, "R8 tri-state off");
    wait_to(c + 30);
    c = cyc; set_pwm(1'b1, 1'b0);
    expect_at(c + 7, 1'b0, 1'b0, "R10 gap after tri");
    expect_at(c + 8, 1'b1, 1'b0, "R10 hs after tri");
    wait_to(c + 10);

    // R9: illegal code acts as middle
    c = cyc; set_pwm(1'b0, 1'b1);
    expect_at(c + 7, 1'b0, 1'b1, "R6 ls on");
    wait_to(c + 10);
    c = cyc; set_pwm(1'b1, 1'b1);
    expect_at(c + 22, 1'b0, 1'b1, "R9 before qualify");
    expect_at(c + 23, 1'b0, 1'b0, "R9 illegal code off");
    wait_to(c + 30);
    c = cyc; set_pwm(1'b0, 1'b1);
    expect_at(c + 6, 1'b0, 1'b0, "R10 gap after illegal");
    expect_at(c + 7, 1'b0, 1'b1, "R10 ls after illegal");
    wait_to(c + 12);

    while (sb.size() > 0) @(negedge clk);
    finish_run();
  end
endmodule